// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines and presents them to one CPU as a single pending event. Each source has one mask bit and one software trigger bit. The trigger bit is ORed with the hardware line, which gives that source's effective request. The CPU interrupt output is high whenever any effective request is unmasked.

Software reads the event register to take an interrupt. The read returns the lowest-numbered unmasked pending source, tagged as a hardware interrupt. On the same clock edge the controller sets that source's mask bit, so the CPU is not interrupted again by a source it is already handling. When the handler is done, software clears the mask with a write-one-to-clear register, and the source can fire again. Mask bits and trigger bits each have their own set and clear register groups, so no read-modify-write is needed. Writes and reads use separate strobes and addresses, so both can happen in the same cycle.

Top module: `irq_automask_ctrl`

## Requirements
- R1: After reset every source is masked, every trigger bit is clear and `irq_o` is low. A mask word reads all ones for the bits that are implemented, and reads 0 for bit positions at or above the source count.
- R2: A masked source never raises `irq_o` and is never returned by an event read.
- R3: A source's effective request is its line ORed with its trigger bit. Group 3 sets trigger bits, group 4 clears them, and a trigger word is read back through group 3.
- R4: When several unmasked requests are pending, the event read returns the lowest source number.
- R5: An event read (group 0) gives a result one cycle after the strobe: `rd_valid` is high, `rd_data[31:16]` holds type code 0 (hardware) and `rd_data[15:0]` holds the source number, with `rd_evt_found` high. If nothing is pending, `rd_data` is 0 and `rd_evt_found` is low.
- R6: The event read sets the delivered source's mask bit on the edge that captures the read. From the next cycle onward, that source no longer drives `irq_o`.
- R7: `irq_o` follows the mask state, the trigger state and the lines combinationally, in the same cycle.
- R8: The address is {group[2:0], word index}. Group 1 sets mask bits, group 2 clears them, and a mask word is read back through group 1. Bit i of word w is source 32*w+i. Only bits written as 1 act; bits written as 0 leave the state unchanged.
- R9: If a mask-clear write and an event read that delivers the same source happen in the same cycle, the source ends up masked.
- R10: A source whose line drops (with its trigger bit clear) stops being pending at once, with no latched state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_IRQ | Level interrupt lines |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address {group, word} |
| wr_data | input | 32 | Write data, one bit per source |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address {group, word} |
| rd_data | output | 32 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result present (one cycle after rd_en) |
| rd_evt_found | output | 1 | Event read delivered a source |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The bench builds the controller with 40 sources instead of the default 64. This gives a second register word that is only partly implemented. Sources that cross a word boundary can then be mixed with first-word sources in priority order. The unimplemented top bits of the second word can be checked to read 0. Source 38 is driven only through its trigger bit, and the mask-clear and auto-mask collision is forced in one cycle with the separate read and write strobes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    GRP_EVENT    = 3'd0,
    GRP_MASK_SET = 3'd1,
    GRP_MASK_CLR = 3'd2,
    GRP_TRIG_SET = 3'd3,
    GRP_TRIG_CLR = 3'd4
  } grp_e;

  localparam logic [15:0] KIND_HW = 16'd0;

  function automatic int words_for(input int n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int WIDX_W = 1,
  localparam int AW    = 3 + WIDX_W
) (
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  output logic [N_IRQ-1:0] mask_set,
  output logic [N_IRQ-1:0] mask_clr,
  output logic [N_IRQ-1:0] trig_set,
  output logic [N_IRQ-1:0] trig_clr
);

  grp_e              grp;
  logic [WIDX_W-1:0] widx;

  assign grp  = grp_e'(wr_addr[AW-1 -: 3]);
  assign widx = wr_addr[WIDX_W-1:0];

  for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
    localparam int WORD = i / WORD_W;
    localparam int POS  = i % WORD_W;
    logic hit;
    assign hit         = wr_en && (widx == WIDX_W'(WORD)) && wr_data[POS];
    assign mask_set[i] = hit && (grp == GRP_MASK_SET);
    assign mask_clr[i] = hit && (grp == GRP_MASK_CLR);
    assign trig_set[i] = hit && (grp == GRP_TRIG_SET);
    assign trig_clr[i] = hit && (grp == GRP_TRIG_CLR);
  end

endmodule

// File: rtl/irqc_srcstate.sv
module irqc_srcstate #(
  parameter int N_IRQ = 64,
  parameter int IW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] mask_set,
  input  logic [N_IRQ-1:0] mask_clr,
  input  logic [N_IRQ-1:0] trig_set,
  input  logic [N_IRQ-1:0] trig_clr,
  input  logic             ack_fire,
  input  logic [IW-1:0]    ack_idx,
  output logic [N_IRQ-1:0] mask_q,
  output logic [N_IRQ-1:0] trig_q
);

  logic [N_IRQ-1:0] auto_vec;
  logic [N_IRQ-1:0] mask_d;
  logic [N_IRQ-1:0] trig_d;

  // auto-mask is ORed last so it overrides a same-cycle clear
  assign auto_vec = ack_fire ? (N_IRQ'(1) << ack_idx) : '0;
  assign mask_d   = (mask_q & ~mask_clr) | mask_set | auto_vec;
  assign trig_d   = (trig_q & ~trig_clr) | trig_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      trig_q <= '0;
    end else begin
      mask_q <= mask_d;
      trig_q <= trig_d;
    end
  end

  // R6 R9
  automask_set_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> mask_q[$past(ack_idx)]);

  // R8
  mask_fall_only_by_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(mask_q) & ~mask_q & ~$past(mask_clr)) == '0));

  // R3
  trig_rise_only_by_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((~$past(trig_q) & trig_q & ~$past(trig_set)) == '0));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N_IRQ = 64,
  parameter int IW    = 6
) (
  input  logic [N_IRQ-1:0] cand,
  output logic             found,
  output logic [IW-1:0]    idx
);

  function automatic logic [IW:0] lowest_set(input logic [N_IRQ-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  logic [IW:0] pick;
  assign pick  = lowest_set(cand);
  assign found = pick[IW];
  assign idx   = pick[IW-1:0];

endmodule

// File: rtl/irq_automask_ctrl.sv
module irq_automask_ctrl
  import irqc_pkg::*;
#(
  parameter int N_IRQ   = 64,
  localparam int WORDS  = words_for(N_IRQ),
  localparam int WIDX_W = idx_bits(WORDS),
  localparam int AW     = 3 + WIDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             rd_evt_found,
  output logic             irq_o
);

  localparam int IW    = idx_bits(N_IRQ);
  localparam int PAD_W = WORDS * WORD_W;

  logic [N_IRQ-1:0] mask_set, mask_clr, trig_set, trig_clr;
  logic [N_IRQ-1:0] mask_q, trig_q;
  logic [N_IRQ-1:0] eff_req;
  logic [N_IRQ-1:0] cand;
  logic             win_found;
  logic [IW-1:0]    win_idx;
  logic             ack_fire;
  grp_e             rd_grp;
  logic [WIDX_W-1:0] rd_widx;
  logic [PAD_W-1:0] mask_pad, trig_pad;
  logic [31:0]      rd_word;
  logic             rd_hit_evt;

  irqc_regdec #(.N_IRQ(N_IRQ), .WIDX_W(WIDX_W)) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .trig_set (trig_set),
    .trig_clr (trig_clr)
  );

  irqc_srcstate #(.N_IRQ(N_IRQ), .IW(IW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .trig_set (trig_set),
    .trig_clr (trig_clr),
    .ack_fire (ack_fire),
    .ack_idx  (win_idx),
    .mask_q   (mask_q),
    .trig_q   (trig_q)
  );

  assign eff_req = irq_lines | trig_q;
  assign cand    = eff_req & ~mask_q;
  assign irq_o   = |cand;

  irqc_prio #(.N_IRQ(N_IRQ), .IW(IW)) u_prio (
    .cand  (cand),
    .found (win_found),
    .idx   (win_idx)
  );

  assign rd_grp     = grp_e'(rd_addr[AW-1 -: 3]);
  assign rd_widx    = rd_addr[WIDX_W-1:0];
  assign rd_hit_evt = rd_en && (rd_grp == GRP_EVENT);
  assign ack_fire   = rd_hit_evt && win_found;

  assign mask_pad = PAD_W'(mask_q);
  assign trig_pad = PAD_W'(trig_q);

  always_comb begin
    rd_word = '0;
    unique case (rd_grp)
      GRP_EVENT: begin
        if (win_found) rd_word = {KIND_HW, 16'(win_idx)};
      end
      GRP_MASK_SET: begin
        for (int w = 0; w < WORDS; w++)
          if (rd_widx == WIDX_W'(w)) rd_word = mask_pad[w*WORD_W +: WORD_W];
      end
      GRP_TRIG_SET: begin
        for (int w = 0; w < WORDS; w++)
          if (rd_widx == WIDX_W'(w)) rd_word = trig_pad[w*WORD_W +: WORD_W];
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      rd_valid     <= 1'b0;
      rd_evt_found <= 1'b0;
    end else begin
      rd_valid     <= rd_en;
      rd_data      <= rd_en ? rd_word : '0;
      rd_evt_found <= ack_fire;
    end
  end

  // R2 R6
  evt_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fire |-> (eff_req[win_idx] && !mask_q[win_idx]));

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    win_found |-> ((cand & ((N_IRQ'(1) << win_idx) - N_IRQ'(1))) == '0));

  // R7
  irq_matches_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == win_found);

  // R5
  resp_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R5
  evt_kind_chk: assert property (@(posedge clk) disable iff (rst)
    rd_evt_found |-> (rd_valid && rd_data[31:16] == KIND_HW));

endmodule

// File: tb/sim_irq_automask_ctrl.sv
module sim_irq_automask_ctrl;

  localparam int CLK_P  = 10;
  localparam int N      = 40;
  localparam int AW     = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  lines = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic          rd_evt_found;
  logic          irq_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_automask_ctrl #(.N_IRQ(N)) u0 (
    .clk          (clk),
    .rst          (rst),
    .irq_lines    (lines),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_evt_found (rd_evt_found),
    .irq_o        (irq_o)
  );

  localparam logic [2:0] G_EVT = 3'd0, G_MSET = 3'd1, G_MCLR = 3'd2,
                         G_TSET = 3'd3, G_TCLR = 3'd4;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] g, input logic w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {g, w}; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] g, input logic w,
                    output logic [31:0] d, output logic f, output logic v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = {g, w};
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data; f = rd_evt_found; v = rd_valid;
  endtask

  // expected event word for a source, type 0 in the upper half
  function automatic logic [31:0] evt_of(input int src);
    return {16'h0000, 16'(src)};
  endfunction

  task automatic remask_all();
    wr(G_MSET, 1'b0, 32'hFFFF_FFFF);
    wr(G_MSET, 1'b1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic f, v;
    chk("R1 irq_o after reset", {31'd0, irq_o}, 32'd0);
    rd(G_MSET, 1'b0, d, f, v);
    chk("R1 mask word0", d, 32'hFFFF_FFFF);
    rd(G_MSET, 1'b1, d, f, v);
    chk("R1 mask word1 upper bits zero", d, 32'h0000_00FF);
    rd(G_TSET, 1'b0, d, f, v);
    chk("R1 trig word0", d, 32'd0);
    rd(G_EVT, 1'b0, d, f, v);
    chk("R5 empty event data", d, 32'd0);
    chk("R5 empty event found", {31'd0, f}, 32'd0);
    chk("R5 rd_valid", {31'd0, v}, 32'd1);
  endtask

  task automatic t_masked();
    logic [31:0] d; logic f, v;
    lines[5] = 1'b1;
    @(negedge clk);
    chk("R2 masked line no irq", {31'd0, irq_o}, 32'd0);
    rd(G_EVT, 1'b0, d, f, v);
    chk("R2 masked line no event", {31'd0, f}, 32'd0);
  endtask

  task automatic t_unmask_ack();
    logic [31:0] d; logic f, v;
    wr(G_MCLR, 1'b0, 32'h0000_0020);
    chk("R7 irq_o after unmask", {31'd0, irq_o}, 32'd1);
    rd(G_MSET, 1'b0, d, f, v);
    chk("R8 only written bit cleared", d, 32'hFFFF_FFDF);
    wr(G_MSET, 1'b0, 32'h0);
    rd(G_MSET, 1'b0, d, f, v);
    chk("R8 zero write no effect", d, 32'hFFFF_FFDF);
    rd(G_EVT, 1'b0, d, f, v);
    chk("R5 event source 5", d, evt_of(5));
    chk("R5 event found", {31'd0, f}, 32'd1);
    chk("R6 irq_o low after ack", {31'd0, irq_o}, 32'd0);
    rd(G_MSET, 1'b0, d, f, v);
    chk("R6 mask bit 5 set by read", d, 32'hFFFF_FFFF);
    lines[5] = 1'b0;
  endtask

  task automatic t_priority();
    logic [31:0] d; logic f, v;
    lines[7] = 1'b1; lines[20] = 1'b1; lines[33] = 1'b1;
    wr(G_MCLR, 1'b1, 32'h0000_0002);
    wr(G_MCLR, 1'b0, (32'd1 << 7) | (32'd1 << 20));
    rd(G_EVT, 1'b0, d, f, v);
    chk("R4 first winner 7", d, evt_of(7));
    rd(G_EVT, 1'b0, d, f, v);
    chk("R4 second winner 20", d, evt_of(20));
    rd(G_EVT, 1'b0, d, f, v);
    chk("R4 word1 winner 33", d, evt_of(33));
    rd(G_EVT, 1'b0, d, f, v);
    chk("R4 drained", {31'd0, f}, 32'd0);
    chk("R6 irq_o low when drained", {31'd0, irq_o}, 32'd0);
    lines = '0;
  endtask

  task automatic t_trigger();
    logic [31:0] d; logic f, v;
    wr(G_TSET, 1'b1, 32'h0000_0040);
    rd(G_TSET, 1'b1, d, f, v);
    chk("R3 trig word1 readback", d, 32'h0000_0040);
    chk("R3 masked trigger no irq", {31'd0, irq_o}, 32'd0);
    wr(G_MCLR, 1'b1, 32'h0000_0040);
    rd(G_EVT, 1'b0, d, f, v);
    chk("R3 trigger-only source 38", d, evt_of(38));
    wr(G_TCLR, 1'b1, 32'h0000_0040);
    wr(G_TSET, 1'b0, 32'h0000_0008);
    wr(G_MCLR, 1'b0, 32'h0000_0008);
    chk("R3 trigger raises irq", {31'd0, irq_o}, 32'd1);
    wr(G_TCLR, 1'b0, 32'h0000_0008);
    chk("R3 trigger clear drops irq", {31'd0, irq_o}, 32'd0);
    remask_all();
  endtask

  task automatic t_level();
    logic [31:0] d; logic f, v;
    wr(G_MCLR, 1'b0, 32'h0000_1000);
    chk("R10 idle unmasked no irq", {31'd0, irq_o}, 32'd0);
    @(negedge clk); lines[12] = 1'b1; #1;
    chk("R7 irq follows line same cycle", {31'd0, irq_o}, 32'd1);
    @(negedge clk); lines[12] = 1'b0; #1;
    chk("R10 line drop clears irq", {31'd0, irq_o}, 32'd0);
    rd(G_EVT, 1'b0, d, f, v);
    chk("R10 no latched event", {31'd0, f}, 32'd0);
    remask_all();
  endtask

  task automatic t_collide();
    logic [31:0] d; logic f, v;
    lines[9] = 1'b1;
    wr(G_MCLR, 1'b0, 32'h0000_0200);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {G_MCLR, 1'b0}; wr_data = 32'h0000_0200;
    rd_en = 1'b1; rd_addr = {G_EVT, 1'b0};
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 delivered source 9", rd_data, evt_of(9));
    chk("R9 auto-mask beats clear irq", {31'd0, irq_o}, 32'd0);
    rd(G_MSET, 1'b0, d, f, v);
    chk("R9 mask bit 9 set", d, 32'hFFFF_FFFF);
    lines[9] = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_masked();
    t_unmask_ack();
    t_priority();
    t_trigger();
    t_level();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule